// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block keeps two 32-bit event counters for the cache and coherence side of a processor core. The cache and coherence logic drive single-cycle pulses into it. These are refill quadword writes tagged with the line type and the quadword index, secondary-cache retries after a hit in the way that was not predicted, tagged by requester, and arrivals of external intervention and invalidate requests together with their secondary-cache hit results. Software picks the event for each counter through a 4-bit code and an enable bit. The same code selects a related but different event on each counter.

A qualifying pulse is captured at one rising edge, and the counter moves at the next one. Software reaches both counters, both control registers and a sticky overflow status through a small register port. Reads are combinational and writes take effect at the clock edge. A software write to a counter wins over an increment that lands in the same cycle. Reset is synchronous and active high.

Top module: `perf_counter_pair`

## Requirements
- R1: While `rst` is high at a rising edge, both counters, both control registers, the overflow status and the pending increments are cleared, so every register reads zero after reset.
- R2: With code 10 on counter 0, only a refill pulse with `refill_is_data`=0 and `refill_qw`=3 counts. Other quadword indices and data-line refills do not count.
- R3: With code 10 on counter 1, only a refill pulse with `refill_is_data`=1 and `refill_qw`=1 counts. Other indices, including 3, and instruction-line refills do not count.
- R4: Code 11 counts `retry_vld` pulses. Counter 0 counts those with `retry_is_data`=0 and counter 1 counts those with `retry_is_data`=1.
- R5: Code 12 on counter 0 counts `ivn_req` pulses. Code 12 on counter 1 counts `ivn_hit` pulses. Both may count in the same cycle.
- R6: Code 13 on counter 0 counts `inv_req` pulses. Code 13 on counter 1 counts `inv_hit` pulses.
- R7: A condition present at rising edge N changes the counter read at edge N+1, by exactly +1. Between software writes, a counter only holds or steps by one.
- R8: With the enable bit (control bit 4) clear, or with any code other than 10 to 13 in control bits 3:0, the counter never increments.
- R9: Register addresses are 0 = control 0, 1 = control 1, 2 = counter 0, 3 = counter 1, 4 = overflow status (bit 0 for counter 0, bit 1 for counter 1). Control registers keep only bits 4:0. Other bits and other addresses read 0.
- R10: A counter write at the same edge as a pending increment stores the written value, and that increment is lost.
- R11: An increment from 0x7FFFFFFF sets that counter's status bit. The bit stays set until a status write with a 1 in its position. If the set and the clear fall on the same edge, the bit stays set.
- R12: An increment from 0xFFFFFFFF wraps the counter to 0 and does not set the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refill_vld | input | 1 | Refill quadword written this cycle |
| refill_is_data | input | 1 | Refill line type: 1 data, 0 instruction |
| refill_qw | input | 2 | Index of the refilled quadword, 0 to 3 |
| retry_vld | input | 1 | Secondary-cache retry started after a hit in the unpredicted way |
| retry_is_data | input | 1 | Retry requester: 1 data cache, 0 instruction cache |
| ivn_req | input | 1 | External intervention request arrived at the tag logic |
| ivn_hit | input | 1 | Intervention request found to hit in the secondary cache |
| inv_req | input | 1 | External invalidate request arrived at the tag logic |
| inv_hit | input | 1 | Invalidate request found to hit in the secondary cache |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for the read and the write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Two pairs of functions can meet at one edge. The first is a software counter write and the delayed increment of an event seen one cycle earlier. The second is an increment that crosses into the top bit and a software clear of the status bit. The bench sets up each collision on purpose: it pulses an event and issues the write or clear on the very next cycle, so both reach the same edge. It also produces them at random with counters preloaded near 0x7FFFFFFF. In every case the readback is judged against a behavioural model in which the write, and the set of the status bit, take priority.

// File: rtl/perf_counter_pair.sv
module perf_counter_pair #(
  parameter int CW  = 32,
  parameter int EVW = 4,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          refill_vld,
  input  logic          refill_is_data,
  input  logic [1:0]    refill_qw,
  input  logic          retry_vld,
  input  logic          retry_is_data,
  input  logic          ivn_req,
  input  logic          ivn_hit,
  input  logic          inv_req,
  input  logic          inv_hit,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata
);
  localparam int CTLW = EVW + 1;
  localparam logic [EVW-1:0] EV_MISS  = EVW'(10);
  localparam logic [EVW-1:0] EV_RETRY = EVW'(11);
  localparam logic [EVW-1:0] EV_IVN   = EVW'(12);
  localparam logic [EVW-1:0] EV_INV   = EVW'(13);
  localparam logic [CW-1:0]  TOP_EDGE = {1'b0, {(CW-1){1'b1}}};

  logic [CTLW-1:0] ctl [2];
  logic [CW-1:0]   cnt [2];
  logic [1:0]      cond, pend, ovf, ctl_we, cnt_we;
  logic            st_we;

  // per-counter event decode: same code, different event on each side
  always_comb begin
    cond = '0;
    case (ctl[0][EVW-1:0])
      EV_MISS:  cond[0] = refill_vld & ~refill_is_data & (refill_qw == 2'd3);
      EV_RETRY: cond[0] = retry_vld & ~retry_is_data;
      EV_IVN:   cond[0] = ivn_req;
      EV_INV:   cond[0] = inv_req;
      default:  cond[0] = 1'b0;
    endcase
    case (ctl[1][EVW-1:0])
      EV_MISS:  cond[1] = refill_vld & refill_is_data & (refill_qw == 2'd1);
      EV_RETRY: cond[1] = retry_vld & retry_is_data;
      EV_IVN:   cond[1] = ivn_hit;
      EV_INV:   cond[1] = inv_hit;
      default:  cond[1] = 1'b0;
    endcase
    cond[0] = cond[0] & ctl[0][EVW];
    cond[1] = cond[1] & ctl[1][EVW];
  end

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      ctl_we[i] = reg_wr && (reg_addr == AW'(i));
      cnt_we[i] = reg_wr && (reg_addr == AW'(2 + i));
    end
  end
  assign st_we = reg_wr && (reg_addr == AW'(4));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ovf  <= '0;
      for (int i = 0; i < 2; i++) begin
        ctl[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      pend <= cond;
      for (int i = 0; i < 2; i++) begin
        if (ctl_we[i]) ctl[i] <= reg_wdata[CTLW-1:0];
        if (cnt_we[i])    cnt[i] <= reg_wdata;
        else if (pend[i]) cnt[i] <= cnt[i] + CW'(1);
        if (pend[i] && !cnt_we[i] && cnt[i] == TOP_EDGE) ovf[i] <= 1'b1;
        else if (st_we && reg_wdata[i])                  ovf[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(0):  reg_rdata = CW'(ctl[0]);
      AW'(1):  reg_rdata = CW'(ctl[1]);
      AW'(2):  reg_rdata = cnt[0];
      AW'(3):  reg_rdata = cnt[1];
      AW'(4):  reg_rdata = CW'(ovf);
      default: reg_rdata = '0;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt[0] == '0 && cnt[1] == '0 && pend == '0 && ovf == '0));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
      cnt_we[g] |=> cnt[g] == $past(reg_wdata));
    assert_unit_step_R7: assert property (@(posedge clk) disable iff (rst)
      !cnt_we[g] |=> (cnt[g] == $past(cnt[g]) || cnt[g] == $past(cnt[g]) + CW'(1)));
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !ctl[g][EVW] |=> !pend[g]);
    assert_sticky_flag_R11: assert property (@(posedge clk) disable iff (rst)
      (ovf[g] && !(st_we && reg_wdata[g])) |=> ovf[g]);
  end
endmodule

// File: tb/tb_perf_counter_pair.sv
`timescale 1ns/1ps
module tb_perf_counter_pair;
  logic clk = 0, rst = 1;
  logic refill_vld = 0, refill_is_data = 0, retry_vld = 0, retry_is_data = 0;
  logic [1:0] refill_qw = 0;
  logic ivn_req = 0, ivn_hit = 0, inv_req = 0, inv_hit = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int vectors = 0, miscmp = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] m_cnt [2];
  logic [4:0]  m_ctl [2];
  bit          m_pend [2];
  bit   [1:0]  m_ovf;

  always #4 clk = ~clk;

  perf_counter_pair dut (.*);

  function automatic bit m_match(int i);
    int code = m_ctl[i][3:0];
    if (!m_ctl[i][4]) return 0;
    if (i == 0) begin
      if (code == 10) return refill_vld && !refill_is_data && refill_qw == 3;
      if (code == 11) return retry_vld && !retry_is_data;
      if (code == 12) return ivn_req;
      if (code == 13) return inv_req;
    end else begin
      if (code == 10) return refill_vld && refill_is_data && refill_qw == 1;
      if (code == 11) return retry_vld && retry_is_data;
      if (code == 12) return ivn_hit;
      if (code == 13) return inv_hit;
    end
    return 0;
  endfunction

  task automatic model_step();
    bit np [2];
    if (rst) begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_ctl[0] = 0; m_ctl[1] = 0;
      m_pend[0] = 0; m_pend[1] = 0; m_ovf = 0;
      return;
    end
    for (int i = 0; i < 2; i++) np[i] = m_match(i);
    if (reg_wr && reg_addr == 4) m_ovf = m_ovf & ~reg_wdata[1:0];
    for (int i = 0; i < 2; i++) begin
      if (reg_wr && reg_addr == 3'(2 + i)) m_cnt[i] = reg_wdata;
      else if (m_pend[i]) begin
        if (m_cnt[i] == 32'h7FFF_FFFF) m_ovf[i] = 1;
        m_cnt[i] = m_cnt[i] + 1;
      end
      if (reg_wr && reg_addr == 3'(i)) m_ctl[i] = reg_wdata[4:0];
      m_pend[i] = np[i];
    end
  endtask

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      0: return {27'd0, m_ctl[0]};
      1: return {27'd0, m_ctl[1]};
      2: return m_cnt[0];
      3: return m_cnt[1];
      4: return {30'd0, m_ovf};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", req, reg_addr, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(cur_req, reg_rdata, m_read(reg_addr));
    refill_vld = 0; retry_vld = 0; ivn_req = 0; ivn_hit = 0;
    inv_req = 0; inv_hit = 0; reg_wr = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc();
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a; #1; chk(req, reg_rdata, exp);
  endtask

  task automatic refill(bit is_data, int qw);
    refill_vld = 1; refill_is_data = is_data; refill_qw = 2'(qw); cyc();
  endtask

  task automatic all_pulses(int n);
    for (int k = 0; k < n; k++) begin
      refill_vld = 1; refill_is_data = k[0]; refill_qw = 2'(k);
      retry_vld = 1; retry_is_data = k[1];
      ivn_req = 1; ivn_hit = 1; inv_req = 1; inv_hit = 1; cyc();
    end
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    rst = 1; idle(3); rst = 0;
    cur_req = "R1";
    for (int a = 0; a < 5; a++) rd("R1", 3'(a), 0);

    cur_req = "R2";
    wr(0, 32'h1A); wr(1, 32'h1A); reg_addr = 2;
    refill(0, 0); refill(0, 1); refill(0, 2); refill(1, 3); refill(0, 3); idle(2);
    rd("R2", 2, 1); rd("R2", 3, 0);

    cur_req = "R3";
    refill(1, 0); refill(1, 1); refill(1, 2); refill(1, 3); refill(0, 1); idle(2);
    rd("R3", 3, 1); rd("R3", 2, 1);

    cur_req = "R4";
    wr(2, 0); wr(3, 0); wr(0, 32'h1B); wr(1, 32'h1B);
    for (int k = 0; k < 5; k++) begin retry_vld = 1; retry_is_data = (k >= 2); cyc(); end
    idle(2); rd("R4", 2, 2); rd("R4", 3, 3);

    cur_req = "R5";
    wr(2, 0); wr(3, 0); wr(0, 32'h1C); wr(1, 32'h1C);
    ivn_req = 1; cyc(); ivn_req = 1; cyc(); ivn_hit = 1; cyc();
    ivn_req = 1; ivn_hit = 1; cyc(); inv_req = 1; inv_hit = 1; cyc(); idle(2);
    rd("R5", 2, 3); rd("R5", 3, 2);

    cur_req = "R6";
    wr(2, 0); wr(3, 0); wr(0, 32'h1D); wr(1, 32'h1D);
    inv_req = 1; cyc(); inv_hit = 1; cyc(); inv_hit = 1; cyc();
    inv_req = 1; inv_hit = 1; cyc(); ivn_req = 1; ivn_hit = 1; cyc(); idle(2);
    rd("R6", 2, 2); rd("R6", 3, 3);

    cur_req = "R7";
    wr(0, 32'h1C); wr(2, 0); reg_addr = 2;
    ivn_req = 1; cyc(); rd("R7", 2, 0);
    cyc(); rd("R7", 2, 1);

    cur_req = "R8";
    wr(2, 0);
    wr(0, 32'h0C); all_pulses(4); idle(2);
    wr(0, 32'h19); all_pulses(4); idle(2);
    wr(0, 32'h1E); all_pulses(4); idle(2);
    wr(0, 32'h1F); all_pulses(4); idle(2);
    wr(0, 32'h10); all_pulses(4); idle(2);
    rd("R8", 2, 0);

    cur_req = "R9";
    wr(1, 32'hFFFF_FFE0); rd("R9", 1, 0);
    wr(1, 32'hFFFF_FFFF); rd("R9", 1, 32'h1F);
    rd("R9", 5, 0); rd("R9", 7, 0);

    cur_req = "R10";
    wr(0, 32'h1C); wr(2, 5);
    ivn_req = 1; cyc(); wr(2, 100); idle(2); rd("R10", 2, 100);

    cur_req = "R11";
    wr(2, 32'h7FFF_FFFE); wr(4, 3);
    ivn_req = 1; cyc(); idle(2); rd("R11", 2, 32'h7FFF_FFFF); rd("R11", 4, 0);
    ivn_req = 1; cyc(); idle(2); rd("R11", 2, 32'h8000_0000); rd("R11", 4, 1);
    wr(4, 0); rd("R11", 4, 1);
    wr(4, 1); rd("R11", 4, 0);
    wr(2, 32'h7FFF_FFFF); ivn_req = 1; cyc(); wr(4, 1);
    rd("R11", 4, 1); rd("R11", 2, 32'h8000_0000);

    cur_req = "R12";
    wr(4, 3); wr(2, 32'hFFFF_FFFF);
    ivn_req = 1; cyc(); idle(2); rd("R12", 2, 0); rd("R12", 4, 0);

    cur_req = "R7";
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 31);
      refill_vld = $urandom_range(0, 1); refill_is_data = $urandom_range(0, 1);
      refill_qw = 2'($urandom_range(0, 3));
      retry_vld = $urandom_range(0, 1); retry_is_data = $urandom_range(0, 1);
      ivn_req = $urandom_range(0, 1); ivn_hit = $urandom_range(0, 1);
      inv_req = $urandom_range(0, 1); inv_hit = $urandom_range(0, 1);
      if (r < 2) begin
        reg_wr = 1; reg_addr = 3'($urandom_range(0, 1));
        reg_wdata = {27'($urandom), 1'b1, 4'($urandom_range(9, 14))};
      end else if (r < 4) begin
        reg_wr = 1; reg_addr = 3'($urandom_range(2, 3));
        reg_wdata = 32'h7FFF_FFFA + 32'($urandom_range(0, 8));
      end else if (r == 4) begin
        reg_wr = 1; reg_addr = 4; reg_wdata = 32'($urandom_range(0, 3));
      end else begin
        reg_addr = 3'($urandom_range(0, 7));
      end
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule